// File: doc/BRIEF.md
# Serial Divisible-by-Five Detector

This block watches a serial bit stream that arrives one bit per clock, most significant bit first, and reports after every accepted bit whether the binary number formed by all bits taken in since reset is an exact multiple of five. The number itself is never stored. The block keeps only its remainder modulo five. Each new bit doubles the old value and adds the bit, so the remainder moves to (2·r + bit) mod 5. Because of this, a stream of any length needs only a five-state machine held in three flip-flops.

An upstream source drives `bit_in` together with the qualifier `bit_valid`. A bit is taken in only on a rising clock edge where `bit_valid` is high. The flag `div_by_five` is a Moore output decoded from the registered remainder. It changes on the edge that takes in a bit, and it covers every bit accepted up to and including that edge. A synchronous active-low reset sets the accumulated value back to zero.

Top module: `mod5_serial_detector`

## Requirements
- R1: While `rst_n` is low at a rising edge, the remainder is cleared to zero, and from the next edge on `div_by_five` reads 1.
- R2: Zero bits accepted while the accumulated value is zero (leading zeros) keep `div_by_five` at 1.
- R3: After each accepted bit, `div_by_five` is 1 exactly when the value of all accepted bits, read MSB first as a binary number, is a multiple of five.
- R4: An accepted bit affects `div_by_five` only from the rising edge that samples it. Before that edge the flag still shows the previous result.
- R5: On an edge where `bit_valid` is 0, `bit_in` is ignored: the remainder holds and `div_by_five` does not change.
- R6: Reset applied in the middle of a stream discards all earlier bits, and the next bits are evaluated as a new number that starts from zero.
- R7: Correctness has no length limit. Streams far longer than 64 bits give the right flag after every bit.
- R8: From value zero, a single 1 bit makes `div_by_five` 0. The three-bit stream 1, 0, 1 (value 5) makes it 1 again, with the flag at 0 after the first and second bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_valid | input | 1 | High when `bit_in` carries a stream bit to accept |
| bit_in | input | 1 | Serial data bit, most significant bit first |
| div_by_five | output | 1 | 1 when the accumulated value is a multiple of five |

## Verification
The bound checker tests on every cycle the properties that can be stated locally. It checks that reset leaves the flag at 1, that an idle cycle holds the flag, that a zero bit taken in at value zero keeps the flag up, that a one bit taken in at value zero drops it, and that the held remainder never takes one of the three unused codes. The exact modulo-five result over long random streams, and the timing in which the flag changes only after the sampling edge, can be shown only by the bench's scenarios. In those scenarios a reference remainder is compared against the flag after every bit. The same holds for restarting after a reset in the middle of a stream.

// File: rtl/mod5_pkg.sv
// Package: types shared by the divisible-by-five detector.
// Assumes a fixed divisor of five, so the remainder needs three bits.
package mod5_pkg;

    localparam int unsigned DIVISOR = 5;
    localparam int unsigned REM_W   = $clog2(DIVISOR);

    // One state for each remainder value; codes 5..7 are unused.
    typedef enum logic [REM_W-1:0] {
        REM0 = 3'd0,
        REM1 = 3'd1,
        REM2 = 3'd2,
        REM3 = 3'd3,
        REM4 = 3'd4
    } rem_e;

endpackage

// File: rtl/mod5_step.sv
// Module: next-remainder logic.
// Computes (2*r + bit) mod 5 from an explicit transition table. Any
// unused input code maps to REM0, so a corrupted state recovers in one clock.
// Assumes the caller decides whether the result is loaded.
module mod5_step
    import mod5_pkg::*;
(
    input  rem_e rem_cur,
    input  logic bit_in,
    output rem_e rem_nxt
);

    // Purpose: look up the remainder after appending one bit.
    always_comb begin
        unique case (rem_cur)
            REM0:    rem_nxt = bit_in ? REM1 : REM0;
            REM1:    rem_nxt = bit_in ? REM3 : REM2;
            REM2:    rem_nxt = bit_in ? REM0 : REM4;
            REM3:    rem_nxt = bit_in ? REM2 : REM1;
            REM4:    rem_nxt = bit_in ? REM4 : REM3;
            default: rem_nxt = REM0;
        endcase
    end

endmodule

// File: rtl/mod5_state_reg.sv
// Module: remainder state register.
// Loads the next remainder when a bit is accepted and holds it otherwise.
// Synchronous active-low reset forces REM0. An unused code is replaced by
// REM0 on the next clock even while idle.
module mod5_state_reg
    import mod5_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  rem_e rem_nxt,
    output rem_e rem_q
);

    logic legal;

    // Purpose: flag whether the held code is one of the five remainders.
    always_comb legal = (rem_q inside {REM0, REM1, REM2, REM3, REM4});

    // Purpose: update, hold or restore the remainder on each rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rem_q <= REM0;
        else if (!legal)
            rem_q <= REM0;
        else if (load)
            rem_q <= rem_nxt;
    end

endmodule

// File: rtl/mod5_flag.sv
// Module: Moore output decode.
// Raises the flag only when the registered remainder is zero.
// Assumes its input comes straight from the state register.
module mod5_flag
    import mod5_pkg::*;
(
    input  rem_e rem_q,
    output logic is_zero
);

    // Purpose: decode remainder zero.
    always_comb is_zero = (rem_q == REM0);

endmodule

// File: rtl/mod5_serial_detector.sv
// Module: top of the serial divisible-by-five detector.
// Accepts one MSB-first bit per edge when bit_valid is high and reports
// whether the accumulated value is a multiple of five. Only the remainder
// is stored, so the stream length is unbounded.
module mod5_serial_detector
    import mod5_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic bit_in,
    output logic div_by_five
);

    rem_e rem_q;
    rem_e rem_nxt;

    mod5_step u_step (
        .rem_cur (rem_q),
        .bit_in  (bit_in),
        .rem_nxt (rem_nxt)
    );

    mod5_state_reg u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (bit_valid),
        .rem_nxt (rem_nxt),
        .rem_q   (rem_q)
    );

    mod5_flag u_flag (
        .rem_q   (rem_q),
        .is_zero (div_by_five)
    );

endmodule

// File: rtl/mod5_serial_detector_chk.sv
// Module: assertion checker bound to the detector top.
// Observes the ports and the registered remainder. It drives nothing.
module mod5_serial_detector_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_valid,
    input logic       bit_in,
    input logic       div_by_five,
    input logic [2:0] rem_q
);

    // R1: reset leaves the flag set on the following cycle.
    assert_reset_flag_R1: assert property (@(posedge clk)
        !rst_n |=> div_by_five);

    // R2: a zero bit taken in at value zero keeps the flag set.
    assert_lead_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (div_by_five && bit_valid && !bit_in) |=> div_by_five);

    // R3: the held remainder never takes an unused code.
    assert_rem_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rem_q < 3'd5);

    // R5: an idle cycle keeps the flag unchanged.
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |=> $stable(div_by_five));

    // R8: a one bit taken in at value zero clears the flag.
    assert_one_from_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (div_by_five && bit_valid && bit_in) |=> !div_by_five);

endmodule

bind mod5_serial_detector mod5_serial_detector_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_valid   (bit_valid),
    .bit_in      (bit_in),
    .div_by_five (div_by_five),
    .rem_q       (rem_q)
);

// File: tb/mod5_serial_detector_tb.sv
// Bench: directed corner cases plus seeded random streams, checked against
// a reference remainder updated as (2*r + bit) % 5 on every accepted bit.
module mod5_serial_detector_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_valid = 1'b0;
    logic bit_in = 1'b0;
    logic div_by_five;

    int unsigned checks = 0;
    int unsigned failures = 0;
    int unsigned ref_rem = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mod5_serial_detector u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_valid   (bit_valid),
        .bit_in      (bit_in),
        .div_by_five (div_by_five)
    );

    function automatic int unsigned ref_next(input int unsigned r, input logic b);
        return (2 * r + int'(b)) % 5;
    endfunction

    function automatic logic ref_flag(input int unsigned r);
        return (r == 0);
    endfunction

    task automatic check(input logic actual, input logic expected, input string req);
        checks++;
        if (actual !== expected) begin
            failures++;
            $display("FAIL %s: div_by_five actual=%0b expected=%0b", req, actual, expected);
        end
    endtask

    // Drive at a falling edge, confirm no early change, then check after the edge.
    task automatic send(input logic v, input logic b, input string req);
        bit_valid = v;
        bit_in    = b;
        #1;
        check(div_by_five, ref_flag(ref_rem), "R4");
        @(negedge clk);
        if (v) ref_rem = ref_next(ref_rem, b);
        check(div_by_five, ref_flag(ref_rem), req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        bit_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        ref_rem = 0;
        check(div_by_five, 1'b1, "R1");
    endtask

    initial begin
        void'($urandom(32'd20240517));
        @(negedge clk);
        do_reset();

        // R2: leading zeros
        for (int i = 0; i < 8; i++) send(1'b1, 1'b0, "R2");

        // R8: 1 -> flag 0, then 1,0,1 -> flag 1
        send(1'b1, 1'b1, "R8");
        check(div_by_five, 1'b0, "R8");
        send(1'b1, 1'b0, "R8");
        check(div_by_five, 1'b0, "R8");
        send(1'b1, 1'b1, "R8");
        check(div_by_five, 1'b1, "R8");

        // R5: idle cycles with toggling data at a nonzero remainder
        send(1'b1, 1'b1, "R3");
        for (int i = 0; i < 6; i++) send(1'b0, i[0], "R5");
        check(div_by_five, 1'b0, "R5");

        // R3: a short directed stream, value 1010 = 10
        do_reset();
        send(1'b1, 1'b1, "R3");
        send(1'b1, 1'b0, "R3");
        send(1'b1, 1'b1, "R3");
        send(1'b1, 1'b0, "R3");
        check(div_by_five, 1'b1, "R3");

        // R6: reset mid-stream, then 1,1,1,1 = 15 from zero
        send(1'b1, 1'b1, "R3");
        send(1'b1, 1'b1, "R3");
        do_reset();
        for (int i = 0; i < 4; i++) send(1'b1, 1'b1, "R6");
        check(div_by_five, 1'b1, "R6");

        // R7: long random streams with random idle gaps
        for (int s = 0; s < 4; s++) begin
            do_reset();
            for (int i = 0; i < 150; i++) begin
                send(($urandom % 4) != 0, $urandom % 2, "R7");
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule